// File: doc/BRIEF.md
# Page Write Collector with Commit Timer

This block sits behind a two-wire serial slave protocol engine, which passes it the bytes of a write transaction. The engine first loads the word address. Each data byte that follows goes into a sixteen-slot page buffer, at the slot named by the low four bits of a running pointer. The upper four bits of the address select the page and do not change for the whole transaction. When the pointer passes slot 15 it wraps to slot 0, so a long burst overwrites bytes collected earlier in the same transaction. A sixteen-bit mask records which slots hold data.

Nothing reaches the 256-byte array until the engine reports a Stop. If the mask is non-empty at that point, a write cycle begins and the busy output rises. During the first sixteen busy cycles a scanner visits slot 0 through slot 15, one slot per cycle. For each marked slot it issues one array write strobe. When the scan ends, the mask is cleared.

Busy stays high for a fixed write-cycle time, counted in system clocks. During that time the engine withholds acknowledges, so the block ignores all transaction inputs. The write-protect input is sampled at Stop. If it is high, the strobes are suppressed, but the full busy time still runs. A Stop with no buffered data starts nothing. This covers acknowledge polls and address-only writes.

Top module: `pgw_top`

## Requirements
- R1: After reset, busy is low and mem_we is low.
- R2: A single byte is committed to mem_addr = {upper four bits of the loaded address, lower four bits of the loaded address}, with mem_wdata equal to that byte. mem_addr[7:4] is the page and mem_addr[3:0] is the slot.
- R3: Each accepted byte advances only the low four bits of the pointer, and slot 15 wraps to slot 0. Every strobe of one commit carries the same mem_addr[7:4], which is the loaded page.
- R4: When more than sixteen bytes arrive, a later byte replaces the earlier byte in the same slot. The commit issues one strobe per slot, carrying the last value.
- R5: No strobe occurs before Stop. Strobes occur only within the first sixteen busy cycles, and within one commit they follow strictly ascending slot order.
- R6: Only the slots written since the last commit are strobed. Other addresses in the page are left unchanged, and the next transaction commits only its own slots.
- R7: If wp is high at Stop, no strobe occurs, and busy still runs its full length.
- R8: A Stop with buffered data raises busy in the following cycle. Busy then stays high for exactly max(WRITE_CYCLES, 16) cycles.
- R9: A Stop with no buffered data leaves busy low and issues no strobe. This holds both for a bare Stop and for a Stop after an address load alone.
- R10: While busy is high, addr_load, byte_vld and stop have no effect. The page being committed does not change, and no ignored byte is committed later.
- R11: wp is sampled only at Stop. Raising wp during the write cycle does not suppress the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_load | input | 1 | Loads the page and slot pointer from addr_in; takes priority over byte_vld |
| addr_in | input | ADDR_W | Word address from the protocol engine |
| byte_vld | input | 1 | One data byte is present on byte_data |
| byte_data | input | DATA_W | Data byte to buffer |
| stop | input | 1 | Stop seen by the protocol engine (one-cycle pulse) |
| wp | input | 1 | Write protect; high blocks array writes |
| busy | output | 1 | Write cycle in progress; the engine gives no acknowledge |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address {page, slot} |
| mem_wdata | output | DATA_W | Array write data |

## Verification
A wrong pointer or page register shows up as a strobe to the wrong array address. That error appears within the sixteen scan cycles after Stop, and the full array comparison at the end of each transaction exposes it. A mask that is not cleared, or that is set while busy, causes extra strobes in the next commit. It also causes a busy pulse after a bare Stop, which is visible one cycle after that Stop. A wrong cycle counter or protect latch shows as a busy length other than the configured value, or as strobes present or missing when the protect input changes.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SCAN = 2'd1,
    PH_HOLD = 2'd2
  } phase_t;

  // The busy window must cover the slot scan.
  function automatic int unsigned hold_len(input int unsigned cyc, input int unsigned slots);
    return (cyc < slots) ? slots : cyc;
  endfunction

endpackage

// File: rtl/pgw_rst_sync.sv
module pgw_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     addr_load,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic                     byte_vld,
  input  logic [DATA_W-1:0]        byte_data,
  input  logic [SLOT_W-1:0]        rd_slot,
  input  logic                     clr_mask,
  output logic [ADDR_W-SLOT_W-1:0] page_q,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic                     any_valid
);

  localparam int unsigned SLOTS  = 1 << SLOT_W;
  localparam int unsigned PAGE_W = ADDR_W - SLOT_W;

  logic [SLOT_W-1:0]             ptr_q, ptr_d;
  logic [PAGE_W-1:0]             page_d;
  logic [SLOTS-1:0]              mask_q, mask_d;
  logic [SLOTS-1:0]              slot_wr;
  logic [SLOTS-1:0][DATA_W-1:0]  cells;
  logic                          load_en;
  logic                          byte_en;

  assign load_en = accept && addr_load;
  assign byte_en = accept && byte_vld && !addr_load;

  // Pointer next state: an address load wins over a byte.
  always_comb begin
    page_d = page_q;
    ptr_d  = ptr_q;
    if (load_en) begin
      page_d = addr_in[ADDR_W-1:SLOT_W];
      ptr_d  = addr_in[SLOT_W-1:0];
    end else if (byte_en) begin
      ptr_d  = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ptr_q  <= '0;
    end else if (load_en || byte_en) begin
      page_q <= page_d;
      ptr_q  <= ptr_d;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] cell_q;

    assign slot_wr[g] = byte_en && (ptr_q == SLOT_W'(g));

    // Slot data: loaded only with its mask bit, so it needs no reset.
    always_ff @(posedge clk) begin
      if (slot_wr[g]) cell_q <= byte_data;
    end

    assign cells[g] = cell_q;

    always_comb begin
      if (clr_mask)        mask_d[g] = 1'b0;
      else if (slot_wr[g]) mask_d[g] = 1'b1;
      else                 mask_d[g] = mask_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign rd_data   = cells[rd_slot];
  assign rd_valid  = mask_q[rd_slot];
  assign any_valid = |mask_q;

endmodule

// File: rtl/pgw_commit_seq.sv
module pgw_commit_seq
  import pgw_pkg::*;
#(
  parameter int unsigned SLOT_W       = 4,
  parameter int unsigned WRITE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop,
  input  logic              any_valid,
  input  logic              wp,
  input  logic              rd_valid,
  output logic              busy,
  output logic [SLOT_W-1:0] scan_slot,
  output logic              mem_we,
  output logic              clr_mask
);

  localparam int unsigned SLOTS = 1 << SLOT_W;
  localparam int unsigned HOLD  = hold_len(WRITE_CYCLES, SLOTS);
  localparam int unsigned CNT_W = $clog2(HOLD);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(HOLD - 1);

  phase_t            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              wp_q, wp_d;
  logic              done;

  assign done = (cnt_q == LAST_CNT);

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    slot_d   = slot_q;
    wp_d     = wp_q;
    clr_mask = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (stop && any_valid) begin
          phase_d = PH_SCAN;
          cnt_d   = '0;
          slot_d  = '0;
          wp_d    = wp;
        end
      end
      PH_SCAN: begin
        cnt_d  = cnt_q + 1'b1;
        slot_d = slot_q + 1'b1;
        if (slot_q == LAST_SLOT) begin
          clr_mask = 1'b1;
          phase_d  = done ? PH_IDLE : PH_HOLD;
        end
      end
      PH_HOLD: begin
        cnt_d = cnt_q + 1'b1;
        if (done) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
      wp_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      slot_q  <= slot_d;
      wp_q    <= wp_d;
    end
  end

  assign busy      = (phase_q != PH_IDLE);
  assign scan_slot = slot_q;
  assign mem_we    = (phase_q == PH_SCAN) && rd_valid && !wp_q;

endmodule

// File: rtl/pgw_top.sv
module pgw_top #(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned SLOT_W       = 4,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned WRITE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  localparam int unsigned PAGE_W = ADDR_W - SLOT_W;

  logic              rst_n_sync;
  logic [PAGE_W-1:0] page_q;
  logic [SLOT_W-1:0] scan_slot;
  logic              rd_valid;
  logic              any_valid;
  logic              clr_mask;

  pgw_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  pgw_page_buf #(
    .ADDR_W (ADDR_W),
    .SLOT_W (SLOT_W),
    .DATA_W (DATA_W)
  ) u_page_buf (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .accept    (!busy),
    .addr_load (addr_load),
    .addr_in   (addr_in),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .rd_slot   (scan_slot),
    .clr_mask  (clr_mask),
    .page_q    (page_q),
    .rd_data   (mem_wdata),
    .rd_valid  (rd_valid),
    .any_valid (any_valid)
  );

  pgw_commit_seq #(
    .SLOT_W       (SLOT_W),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_commit_seq (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .stop      (stop),
    .any_valid (any_valid),
    .wp        (wp),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .scan_slot (scan_slot),
    .mem_we    (mem_we),
    .clr_mask  (clr_mask)
  );

  assign mem_addr = {page_q, scan_slot};

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker
  import pgw_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned SLOT_W       = 4,
  parameter int unsigned WRITE_CYCLES = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_load,
  input logic              byte_vld,
  input logic              stop,
  input logic              wp,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);

  localparam int unsigned SLOTS = 1 << SLOT_W;
  localparam int unsigned HOLD  = hold_len(WRITE_CYCLES, SLOTS);
  localparam int unsigned BC_W  = $clog2(HOLD) + 1;

  logic [BC_W-1:0] bcnt_q;
  logic            wp_seen_q;
  logic            data_seen_q;

  // Index of the current busy cycle within the write cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt_q <= '0;
    else if (busy) bcnt_q <= bcnt_q + 1'b1;
    else           bcnt_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_seen_q   <= 1'b0;
      data_seen_q <= 1'b0;
    end else if (stop && !busy) begin
      wp_seen_q   <= wp;
      data_seen_q <= 1'b0;
    end else if (byte_vld && !busy && !addr_load) begin
      data_seen_q <= 1'b1;
    end
  end

  AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && (bcnt_q < BC_W'(SLOTS)))); // R5

  AST_STROBE_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[SLOT_W-1:0] > $past(mem_addr[SLOT_W-1:0]))); // R5

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt_q < BC_W'(HOLD))); // R8

  AST_BUSY_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(bcnt_q) == BC_W'(HOLD - 1))); // R8

  AST_PROTECT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wp_seen_q); // R7

  AST_EMPTY_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy && !data_seen_q) |=> !busy); // R9

  AST_DATA_STOP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy && data_seen_q) |=> busy); // R8

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr[ADDR_W-1:SLOT_W] == $past(mem_addr[ADDR_W-1:SLOT_W]))); // R10

endmodule

bind pgw_top pgw_checker #(
  .ADDR_W       (ADDR_W),
  .SLOT_W       (SLOT_W),
  .WRITE_CYCLES (WRITE_CYCLES)
) u_pgw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_load (addr_load),
  .byte_vld  (byte_vld),
  .stop      (stop),
  .wp        (wp),
  .busy      (busy),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/tb_pgw_top.sv
module tb_pgw_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 40;
  localparam int SLOTS      = 16;

  logic       clk;
  logic       rst_n;
  logic       addr_load;
  logic [7:0] addr_in;
  logic       byte_vld;
  logic [7:0] byte_data;
  logic       stop;
  logic       wp;
  logic       busy;
  logic       mem_we;
  logic [7:0] mem_addr;
  logic [7:0] mem_wdata;

  pgw_top #(.ADDR_W(8), .SLOT_W(4), .DATA_W(8), .WRITE_CYCLES(W)) dut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop(stop), .wp(wp),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] obs_mem [256];
  logic [7:0] exp_mem [256];

  int wr_count, busy_count, late_err, order_err, last_slot, busy_idx;

  logic [3:0] e_ptr, e_page;
  logic [7:0] e_buf [SLOTS];
  bit         e_valid [SLOTS];

  // Port monitor: records the array writes seen at the strobe.
  always @(negedge clk) begin
    if (busy === 1'b1) busy_count++;
    if (mem_we === 1'b1) begin
      wr_count++;
      if (busy_idx >= SLOTS) late_err++;
      if (int'(mem_addr[3:0]) <= last_slot) order_err++;
      last_slot = int'(mem_addr[3:0]);
      obs_mem[mem_addr] = mem_wdata;
    end
    if (busy === 1'b1) busy_idx++;
    else               busy_idx = 0;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic clr_mon();
    wr_count = 0; busy_count = 0; late_err = 0; order_err = 0; last_slot = -1;
  endtask

  task automatic set_addr(input logic [7:0] a, input bit track);
    if (track) begin
      clr_mon();
      e_page = a[7:4];
      e_ptr  = a[3:0];
    end
    addr_load = 1'b1; addr_in = a;
    step();
    addr_load = 1'b0;
  endtask

  task automatic send_bytes(input int n, input int seed, input bit track);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'(seed + i * 37);
      byte_vld = 1'b1; byte_data = d;
      step();
      byte_vld = 1'b0;
      if (track) begin
        e_buf[e_ptr]   = d;
        e_valid[e_ptr] = 1'b1;
        e_ptr          = e_ptr + 4'd1;
      end
    end
  endtask

  // mode 0: plain, 1: disturb inputs while busy, 2: raise wp while busy
  task automatic commit(input string req, input bit wpv, input int mode);
    int exp_w;
    bit any;
    int mism;
    exp_w = 0; any = 0; mism = 0;
    check("R5", "strobes before stop", wr_count, 0);
    for (int s = 0; s < SLOTS; s++) begin
      if (e_valid[s]) begin
        any = 1;
        if (!wpv) begin
          exp_w++;
          exp_mem[{e_page, 4'(s)}] = e_buf[s];
        end
      end
      e_valid[s] = 1'b0;
    end
    clr_mon();
    wp = wpv; stop = 1'b1;
    step();
    stop = 1'b0;
    if (mode == 1) begin
      set_addr(8'h90, 1'b0);
      send_bytes(3, 99, 1'b0);
      stop = 1'b1;
      step();
      stop = 1'b0;
    end
    if (mode == 2) wp = 1'b1;
    repeat (W + 4) step();
    wp = 1'b0;
    check(req, "strobe count", wr_count, exp_w);
    check("R8", "busy cycles", busy_count, any ? W : 0);
    check("R5", "strobes outside slot window", late_err, 0);
    check("R5", "slot order violations", order_err, 0);
    for (int a = 0; a < 256; a++) if (obs_mem[a] !== exp_mem[a]) mism++;
    check(req, "array mismatches", mism, 0);
  endtask

  task automatic bare_stop(input string req);
    clr_mon();
    stop = 1'b1;
    step();
    stop = 1'b0;
    repeat (W + 4) step();
    check(req, "busy cycles after empty stop", busy_count, 0);
    check(req, "strobes after empty stop", wr_count, 0);
  endtask

  task automatic t_reset();
    repeat (3) step();
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "mem_we after reset", int'(mem_we), 0);
  endtask

  task automatic t_byte();
    set_addr(8'h35, 1'b1); send_bytes(1, 8'hA5, 1'b1); commit("R2", 1'b0, 0);
  endtask

  task automatic t_wrap();
    set_addr(8'h3E, 1'b1); send_bytes(4, 8'h11, 1'b1); commit("R3", 1'b0, 0);
  endtask

  task automatic t_overflow();
    set_addr(8'h50, 1'b1); send_bytes(18, 8'h21, 1'b1); commit("R4", 1'b0, 0);
  endtask

  task automatic t_sparse();
    set_addr(8'h72, 1'b1); send_bytes(2, 8'h44, 1'b1); commit("R6", 1'b0, 0);
    set_addr(8'h79, 1'b1); send_bytes(1, 8'h5C, 1'b1); commit("R6", 1'b0, 0);
  endtask

  task automatic t_protect();
    set_addr(8'h35, 1'b1); send_bytes(3, 8'h77, 1'b1); commit("R7", 1'b1, 0);
  endtask

  task automatic t_wp_sampled();
    set_addr(8'hA0, 1'b1); send_bytes(5, 8'h3B, 1'b1); commit("R11", 1'b0, 2);
  endtask

  task automatic t_empty();
    bare_stop("R9");
    set_addr(8'hC4, 1'b0);
    bare_stop("R9");
  endtask

  task automatic t_ignore_busy();
    set_addr(8'hB3, 1'b1); send_bytes(2, 8'h66, 1'b1); commit("R10", 1'b0, 1);
    bare_stop("R10");
  endtask

  initial begin
    rst_n = 1'b1; addr_load = 1'b0; addr_in = '0; byte_vld = 1'b0;
    byte_data = '0; stop = 1'b0; wp = 1'b0;
    busy_idx = 0;
    clr_mon();
    e_ptr = '0; e_page = '0;
    for (int a = 0; a < 256; a++) begin obs_mem[a] = 8'h00; exp_mem[a] = 8'h00; end
    for (int s = 0; s < SLOTS; s++) begin e_buf[s] = 8'h00; e_valid[s] = 1'b0; end
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_byte();
    t_wrap();
    t_overflow();
    t_sparse();
    t_protect();
    t_wp_sampled();
    t_empty();
    t_ignore_busy();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule